// File: doc/BRIEF.md
# Shared-Pin Serial Configuration Port

This block is the device side of a three-pin serial link on a low-frequency receiver. A host reaches the receiver's configuration registers through it: it can write a register, read one back, or send a frame that carries only a command. One pin is a select input that is high when the device is idle. The second pin has two roles. While the device is deselected it is an open-drain alert output. While the device is selected it is the serial clock input. The third pin also has two roles. While the device is deselected it carries received data, either the demodulated stream or the carrier clock. During a transfer it takes serial data in, and it turns around to drive data out only during the data phase of a register read.

All three pins are brought into the system clock domain through synchronizers, and every action is taken on edges found in that domain. The block has eight 9-bit registers. Register 0 chooses what appears on the data pin while the device is idle. Bit 8 of register 2 requests the capacitor discharge switch, and that request is honoured only when register 0 selects the signal-strength output. Every pin enable leaves a flop, and the data-pin enable is forced low in any cycle that follows a change of the synchronized select.

Top module: `pscfg_top`

## Requirements
- R1: A frame is 16 bits long and is sent most significant bit first. Bits 15..13 are the command, bits 12..9 the address and bits 8..0 the data. Each bit is sampled on a rising clock edge seen while the device is selected.
- R2: Command 010 writes the data field into the addressed register. The write happens only when select rises after exactly 16 counted rising edges. Addresses 8..15 write nothing, and a read of such an address returns 0.
- R3: Command 011 drives the register's contents out of the data pin. Bit 8 comes first and appears from the falling edge after the 7th rising edge, and one more bit follows on each later falling edge. In every other frame, and in the header of a read, the data pin is not driven while the device is selected.
- R4: Command 000 with exactly 16 edges raises note_pulse_o for one cycle after select rises, with note_arg_o equal to the address field.
- R5: Commands 001 and 100..111 change no register and raise no pulse.
- R6: A frame with fewer or more than 16 rising edges is discarded. Every fall of select starts a new frame from an empty shifter.
- R7: A rising clock edge that reaches the synchronized domain in the same cycle as the rise of select is not counted.
- R8: While the device is deselected, the register 0 field in bits 1..0 chooses what the data pin does. 00 and 11 drive demod_i, 01 drives carrier_i, and 10 (signal strength) leaves the pin undriven.
- R9: While the device is deselected, alert_oe_o follows alert_req_i. While it is selected, alert_oe_o is 0.
- R10: dischg_o is 1 only while the device is deselected, register 0 bits 1..0 equal 10 and register 2 bit 8 is set. It is never 1 while the data pin is driven.
- R11: sdio_oe_o is 0 in the cycle after any change of the synchronized select.
- R12: After reset every register holds 0. The data pin therefore drives demod_i when idle, dischg_o is 0, and every read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Select pin, low while a transfer is in progress |
| sclk_i | input | 1 | Clock/alert pin read side (serial clock while selected) |
| sdio_i | input | 1 | Data pin read side (serial data in) |
| alert_req_i | input | 1 | Alert request from the receiver |
| demod_i | input | 1 | Demodulated receive data |
| carrier_i | input | 1 | Recovered carrier clock |
| alert_oe_o | output | 1 | Pulls the clock/alert pin low when 1 |
| sdio_o | output | 1 | Data pin output value |
| sdio_oe_o | output | 1 | Data pin output enable |
| dischg_o | output | 1 | Discharge switch enable |
| note_pulse_o | output | 1 | One-cycle strobe for a command-only frame |
| note_arg_o | output | 4 | Address field of the last command-only frame |

## Verification
Two things can land in the same synchronized cycle: the last rising clock edge of a frame and the rise of select that commits it. When they coincide, the edge is dropped and the frame fails its length check. The bench provokes this by changing both pins in the same time step at the end of a write. It then reads the register back and expects the old value, and a normal write that follows must still commit. Random frames mix writes, reads, command-only frames, unused codes and wrong lengths. After each one, the idle pin function, the alert, the discharge switch and the pulse count are compared with a model held in the bench.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;
  localparam logic [2:0] OP_NOTIFY = 3'b000;
  localparam logic [2:0] OP_WRITE  = 3'b010;
  localparam logic [2:0] OP_READ   = 3'b011;

  typedef enum logic [1:0] {
    SEL_DEMOD    = 2'b00,
    SEL_CARRIER  = 2'b01,
    SEL_STRENGTH = 2'b10,
    SEL_SPARE    = 2'b11
  } outsel_e;
endpackage

// File: rtl/pscfg_sync.sv
module pscfg_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q, stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pscfg_frame.sv
module pscfg_frame
  import pscfg_pkg::*;
#(
  parameter int CMD_W  = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              tx_bit,
  output logic              rd_act,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              note_pulse,
  output logic [ADDR_W-1:0] note_arg
);
  localparam int HDR_W   = CMD_W + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               rd_act_q, rd_act_d;
  logic [DATA_W-1:0]  tx_q, tx_d;
  logic               note_q, note_d;
  logic [ADDR_W-1:0]  narg_q, narg_d;

  logic             full, hdr_done;
  logic [CMD_W-1:0] hdr_cmd, fr_cmd;

  assign full     = (cnt_q == CNT_W'(FRAME_W));
  assign hdr_done = (cnt_q == CNT_W'(HDR_W));
  assign hdr_cmd  = shreg_q[HDR_W-1 -: CMD_W];
  assign fr_cmd   = shreg_q[FRAME_W-1 -: CMD_W];
  assign wr_addr  = shreg_q[DATA_W +: ADDR_W];
  assign wr_data  = shreg_q[DATA_W-1:0];
  assign rd_addr  = shreg_q[ADDR_W-1:0];
  assign wr_en    = cs_rise && full && (fr_cmd == OP_WRITE);

  always_comb begin
    shreg_d  = shreg_q;
    cnt_d    = cnt_q;
    rd_act_d = rd_act_q;
    tx_d     = tx_q;
    note_d   = 1'b0;
    narg_d   = narg_q;
    if (cs_fall) begin
      shreg_d  = '0;
      cnt_d    = '0;
      rd_act_d = 1'b0;
      tx_d     = '0;
    end else begin
      if (sclk_rise) begin
        shreg_d = {shreg_q[FRAME_W-2:0], sdi};
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
      end
      if (sclk_fall) begin
        if (hdr_done && (hdr_cmd == OP_READ)) begin
          tx_d     = rd_word;
          rd_act_d = 1'b1;
        end else if (rd_act_q) begin
          tx_d = {tx_q[DATA_W-2:0], 1'b0};
        end
      end
      if (cs_rise) begin
        rd_act_d = 1'b0;
        if (full && (fr_cmd == OP_NOTIFY)) begin
          note_d = 1'b1;
          narg_d = wr_addr;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      cnt_q    <= '0;
      rd_act_q <= 1'b0;
      tx_q     <= '0;
      note_q   <= 1'b0;
      narg_q   <= '0;
    end else begin
      shreg_q  <= shreg_d;
      cnt_q    <= cnt_d;
      rd_act_q <= rd_act_d;
      tx_q     <= tx_d;
      note_q   <= note_d;
      narg_q   <= narg_d;
    end
  end

  assign tx_bit     = tx_q[DATA_W-1];
  assign rd_act     = rd_act_q;
  assign note_pulse = note_q;
  assign note_arg   = narg_q;
endmodule

// File: rtl/pscfg_regs.sv
module pscfg_regs
  import pscfg_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 9,
  parameter int NREG    = 8,
  parameter int SEL_REG = 0,
  parameter int DIS_REG = 2,
  parameter int DIS_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  output outsel_e           outsel,
  output logic              dis_req
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [NREG-1:0][DATA_W-1:0] regs_q, regs_d;
  logic                        rd_hit;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assign regs_d[r] = (wr_en && (wr_addr == ADDR_W'(r))) ? wr_data : regs_q[r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  assign rd_hit  = ({1'b0, rd_addr} < (ADDR_W+1)'(NREG));
  assign rd_word = rd_hit ? regs_q[rd_addr[IDX_W-1:0]] : '0;
  assign outsel  = outsel_e'(regs_q[SEL_REG][1:0]);
  assign dis_req = regs_q[DIS_REG][DIS_BIT];
endmodule

// File: rtl/pscfg_top.sv
module pscfg_top
  import pscfg_pkg::*;
#(
  parameter int CMD_W  = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 9,
  parameter int NREG   = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  input  logic              alert_req_i,
  input  logic              demod_i,
  input  logic              carrier_i,
  output logic              alert_oe_o,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic              dischg_o,
  output logic              note_pulse_o,
  output logic [ADDR_W-1:0] note_arg_o
);
  logic [1:0] rst_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ni = rst_q[1];

  logic cs_s, sclk_s, sdi_s;
  pscfg_sync #(.WIDTH(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_ni),
    .d({cs_n_i, sclk_i, sdio_i}),
    .q({cs_s, sclk_s, sdi_s})
  );

  logic cs_q, sclk_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  logic cs_fall, cs_rise, sclk_rise, sclk_fall, desel_st, sel_st;
  assign cs_fall   = !cs_s &&  cs_q;
  assign cs_rise   =  cs_s && !cs_q;
  assign desel_st  =  cs_s &&  cs_q;
  assign sel_st    = !cs_s && !cs_q;
  assign sclk_rise = !cs_s &&  sclk_s && !sclk_q;
  assign sclk_fall = !cs_s && !sclk_s &&  sclk_q;

  logic [DATA_W-1:0] rd_word, wr_data;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              tx_bit, rd_act, wr_en, dis_req;
  outsel_e           outsel;

  pscfg_frame #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_ni),
    .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi(sdi_s),
    .rd_word(rd_word), .rd_addr(rd_addr),
    .tx_bit(tx_bit), .rd_act(rd_act),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .note_pulse(note_pulse_o), .note_arg(note_arg_o)
  );

  pscfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_ni),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_word(rd_word),
    .outsel(outsel), .dis_req(dis_req)
  );

  logic oe_d, oe_q, dout_d, dout_q, alert_d, alert_q, dis_d, dis_q;
  logic strength_sel;

  assign strength_sel = (outsel == SEL_STRENGTH);

  always_comb begin
    oe_d    = (desel_st && !strength_sel) || (sel_st && rd_act);
    dout_d  = cs_s ? ((outsel == SEL_CARRIER) ? carrier_i : demod_i) : tx_bit;
    alert_d = desel_st && alert_req_i;
    dis_d   = desel_st && strength_sel && dis_req;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q    <= 1'b0;
      dout_q  <= 1'b0;
      alert_q <= 1'b0;
      dis_q   <= 1'b0;
    end else begin
      oe_q    <= oe_d;
      dout_q  <= dout_d;
      alert_q <= alert_d;
      dis_q   <= dis_d;
    end
  end

  assign sdio_oe_o  = oe_q;
  assign sdio_o     = dout_q;
  assign alert_oe_o = alert_q;
  assign dischg_o   = dis_q;
endmodule

// File: rtl/pscfg_checker.sv
module pscfg_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic cs_q,
  input logic sdio_oe_o,
  input logic alert_oe_o,
  input logic dischg_o,
  input logic note_pulse_o
);
  assert_oe_turnaround_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s != cs_q) |=> !sdio_oe_o);

  assert_alert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !alert_oe_o);

  assert_dischg_no_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dischg_o |-> !sdio_oe_o);

  assert_dischg_selected_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !dischg_o);

  assert_note_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    note_pulse_o |=> !note_pulse_o);

  assert_note_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    note_pulse_o |-> !sdio_oe_o);
endmodule

bind pscfg_top pscfg_checker u_chk (
  .clk(clk), .rst_n(rst_ni), .cs_s(cs_s), .cs_q(cs_q),
  .sdio_oe_o(sdio_oe_o), .alert_oe_o(alert_oe_o),
  .dischg_o(dischg_o), .note_pulse_o(note_pulse_o)
);

// File: tb/sim_pscfg_top.sv
`timescale 1ns/1ps
module sim_pscfg_top;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic alert_req = 1'b0, demod = 1'b0, carrier = 1'b0;
  logic alert_oe_o, sdio_o, sdio_oe_o, dischg_o, note_pulse_o;
  logic [3:0] note_arg_o;

  always #2.5 clk = ~clk;

  pscfg_top u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdio_i(sdin),
    .alert_req_i(alert_req), .demod_i(demod), .carrier_i(carrier),
    .alert_oe_o(alert_oe_o), .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o),
    .dischg_o(dischg_o), .note_pulse_o(note_pulse_o), .note_arg_o(note_arg_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int note_cnt = 0;
  logic [3:0] note_last = '0;
  logic [8:0] model [8];
  int exp_notes = 0;
  logic [3:0] exp_arg = '0;

  always @(negedge clk) if (note_pulse_o) begin
    note_cnt++;
    note_last = note_arg_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [8:0] exp_read(input logic [3:0] a);
    return (a < 8) ? model[a[2:0]] : 9'd0;
  endfunction

  task automatic frame(input logic [15:0] w, input int nclk, input bit merge,
                       output logic [8:0] rd, output bit drv_ok, output bit alert_ok);
    rd = '0; drv_ok = 1; alert_ok = 1;
    @(negedge clk);
    cs_n = 1'b0; sclk = 1'b0;
    wcyc(6);
    if (alert_oe_o) alert_ok = 0;
    for (int i = 0; i < nclk; i++) begin
      sclk = 1'b0;
      sdin = (i < 16) ? w[15-i] : 1'b0;
      wcyc(HALF);
      if (i >= 7 && i < 16 && w[15:13] == 3'b011) begin
        if (!sdio_oe_o) drv_ok = 0;
        rd = {rd[7:0], sdio_o};
      end else if (sdio_oe_o) drv_ok = 0;
      if (merge && i == nclk - 1) begin
        sclk = 1'b1; cs_n = 1'b1;
      end else begin
        sclk = 1'b1;
        wcyc(HALF);
      end
    end
    if (!merge) begin
      sclk = 1'b0; wcyc(HALF); cs_n = 1'b1;
    end
    wcyc(10);
    sclk = 1'b0;
    wcyc(4);
  endtask

  task automatic idle_check(input string tag);
    logic [1:0] s;
    bit eoe, eo, ed;
    demod = 1'($urandom); carrier = 1'($urandom); alert_req = 1'($urandom);
    wcyc(4);
    s = model[0][1:0];
    eoe = (s != 2'b10);
    eo = (s == 2'b01) ? carrier : demod;
    ed = (s == 2'b10) && model[2][8];
    chk(sdio_oe_o == eoe, {"R8 idle enable ", tag}, sdio_oe_o, eoe);
    if (eoe) chk(sdio_o == eo, {"R8 idle data ", tag}, sdio_o, eo);
    chk(alert_oe_o == alert_req, {"R9 idle alert ", tag}, alert_oe_o, alert_req);
    chk(dischg_o == ed, {"R10 discharge ", tag}, dischg_o, ed);
  endtask

  task automatic run(input logic [2:0] cmd, input logic [3:0] a, input logic [8:0] d,
                     input int nclk, input bit merge, input string tag);
    logic [8:0] rd;
    bit dok, aok;
    logic [8:0] er;
    er = exp_read(a);
    alert_req = 1'b1;
    frame({cmd, a, d}, nclk, merge, rd, dok, aok);
    chk(aok, {"R9 alert released while selected ", tag}, 0, 0);
    chk(dok, {"R3 data pin direction ", tag}, 0, 0);
    if (cmd == 3'b011) chk(rd == er, {"R3 read data ", tag}, rd, er);
    if (nclk == 16 && !merge) begin
      if (cmd == 3'b010 && a < 8) model[a[2:0]] = d;
      if (cmd == 3'b000) begin exp_notes++; exp_arg = a; end
    end
    chk(note_cnt == exp_notes, {"R4 R5 notify count ", tag}, note_cnt, exp_notes);
    if (exp_notes > 0) chk(note_last == exp_arg, {"R4 notify arg ", tag}, note_last, exp_arg);
  endtask

  task automatic read_back(input logic [3:0] a, input string tag);
    run(3'b011, a, 9'h000, 16, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] bad_codes [5];
    void'($urandom(32'h5EED1));
    bad_codes[0] = 3'b001; bad_codes[1] = 3'b100; bad_codes[2] = 3'b101;
    bad_codes[3] = 3'b110; bad_codes[4] = 3'b111;
    for (int k = 0; k < 8; k++) model[k] = '0;
    wcyc(5);
    rst_n = 1'b1;
    wcyc(8);
    // R12 reset state
    chk(dischg_o == 1'b0, "R12 discharge after reset", dischg_o, 0);
    chk(sdio_oe_o == 1'b1, "R12 idle drive after reset", sdio_oe_o, 1);
    chk(alert_oe_o == 1'b0, "R12 alert after reset", alert_oe_o, 0);
    for (int a = 0; a < 8; a++) read_back(4'(a), "R12 reset readback");

    // R1 R2 directed write/read, including out-of-range address
    run(3'b010, 4'd5, 9'h1A5, 16, 0, "R1 write");
    read_back(4'd5, "R1 R2 readback");
    run(3'b010, 4'd12, 9'h1FF, 16, 0, "R2 write high addr");
    read_back(4'd12, "R2 high addr reads zero");
    // R6 short and long frames discarded
    run(3'b010, 4'd5, 9'h0F0, 15, 0, "R6 short");
    run(3'b010, 4'd5, 9'h0F0, 17, 0, "R6 long");
    read_back(4'd5, "R6 unchanged");
    // R7 last edge merged with deselect: not counted, next frame fresh
    run(3'b010, 4'd3, 9'h133, 16, 1, "R7 merged");
    read_back(4'd3, "R7 unchanged");
    run(3'b010, 4'd3, 9'h0C3, 16, 0, "R7 R6 fresh frame");
    read_back(4'd3, "R7 following write");
    // R5 unused codes
    for (int b = 0; b < 5; b++) run(bad_codes[b], 4'd3, 9'h1FF, 16, 0, "R5 unused code");
    read_back(4'd3, "R5 unchanged");
    // R4 command-only
    run(3'b000, 4'd9, 9'h055, 16, 0, "R4 notify");
    // R8 R10 modes
    run(3'b010, 4'd2, 9'h100, 16, 0, "R10 set bit");
    idle_check("R10 demod mode off");
    run(3'b010, 4'd0, 9'h002, 16, 0, "R10 strength mode");
    idle_check("R10 strength on");
    run(3'b010, 4'd0, 9'h001, 16, 0, "R8 carrier mode");
    idle_check("R8 carrier");
    run(3'b010, 4'd0, 9'h003, 16, 0, "R8 spare mode");
    idle_check("R8 spare");

    // R11 turnaround: random mix
    for (int it = 0; it < 70; it++) begin
      int r;
      logic [3:0] a;
      logic [2:0] c;
      int n;
      r = $urandom_range(0, 9);
      a = ($urandom_range(0, 9) < 3) ? (($urandom_range(0, 1) == 1) ? 4'd2 : 4'd0) : 4'($urandom);
      n = 16;
      if (r <= 3) c = 3'b010;
      else if (r <= 6) c = 3'b011;
      else if (r == 7) c = 3'b000;
      else if (r == 8) c = bad_codes[$urandom_range(0, 4)];
      else begin c = 3'b010; n = ($urandom_range(0, 1) == 1) ? 17 : $urandom_range(1, 15); end
      run(c, a, 9'($urandom), n, 0, "R11 random");
      idle_check("R11 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule